// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of peripheral sources, grouped in banks of 32, and presents them to a processor through a small 32-bit register bus. For each bank, software holds an enable (mask) word and a routing word. The routing word sends each source either to the normal interrupt output or to the fast interrupt output. Read-only views show the raw input levels, the enabled sources routed to the normal output, and the enabled sources routed to the fast output.

A table of priority slots, one per source, lets software rank the sources. Each slot names a source and carries a valid flag. A single "winner" register then returns the source number of the lowest-numbered valid slot whose source is enabled, pending and routed to the normal output, together with a flag. A service loop reads the winner, services that source and acknowledges it by clearing its enable bit. The loop stops when the flag reads 0. A control bit selects whether the registered idle-wake output follows every raw request or only the enabled ones.

Register map (byte addresses, word aligned): bank 0 at 0x000, bank 1 at 0x09C, bank 2 at 0x130, bank 3 at 0x244. Within a bank: +0x00 normal view, +0x04 enable, +0x08 routing, +0x0C fast view, +0x10 raw levels. Bank 0 only: +0x14 control, +0x18 winner. Priority slots 0–31 start at 0x01C, slots 32–63 at 0x0B0 and slots 64–127 at 0x144, 4 bytes apart.

Top module: `irqc_top`

## Requirements
- R1: After reset, every enable, routing, control and slot register reads 0, the winner register reads 0, and irq_o, fiq_o and wake_o are 0.
- R2: The raw view (bank +0x10) returns the current levels of that bank's 32 inputs, with bit i of bank b standing for source 32*b+i, and no latching.
- R3: The normal view (+0x00) reads raw AND enable AND NOT routing. The fast view (+0x0C) reads raw AND enable AND routing. Clearing an enable bit removes the source from both views at once.
- R4: Enable (+0x04) and routing (+0x08) are read/write. In the routing word, 0 selects the normal output and 1 selects the fast output.
- R5: irq_o is registered. One clock after the inputs, it equals the OR of all normal-view bits across banks. fiq_o is the same for the fast-view bits.
- R6: A slot register holds a 7-bit source number in bits 6:0 and a valid flag in bit 31. All other bits read 0. Slot i sits at 0x01C+4i, 0x0B0+4(i-32) or 0x144+4(i-64).
- R7: The winner register (0x018) reads bit 31 = 1 and bits 30:16 = the source number of the lowest-index valid slot whose source shows in the normal view. All other bits read 0. If no slot qualifies, the register reads 0.
- R8: A slot without its valid flag, or naming a source number at or above the source count, never wins. Sources routed to the fast output never win.
- R9: Control bit 0 (0x014) is read/write. wake_o is registered. One clock later, it equals the OR of all enabled pending sources when the bit is 1, and the OR of all raw inputs when the bit is 0.
- R10: Writes to the views and to the winner register have no effect. Reads of unmapped or misaligned addresses return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32*NUM_BANKS | Level request inputs, one per source |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |
| wake_o | output | 1 | Registered idle-wake request |

## Verification
The bench builds the block with its defaults: two banks, 64 sources and 64 slots, and a 10-bit address. This covers a bank boundary, slots on both sides of the 0x0B0 gap, and slot numbers 64–127. Numbers in that range are out of range for this build, so the rule that such slots never win can be tested. With only two banks, the bank 2 window and the third slot range are unmapped, which exercises the read-as-zero and write-ignored paths.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int OFF_NORM  = 'h00;
    localparam int OFF_EN    = 'h04;
    localparam int OFF_ROUTE = 'h08;
    localparam int OFF_FAST  = 'h0C;
    localparam int OFF_RAW   = 'h10;
    localparam int OFF_CTRL  = 'h14;
    localparam int OFF_WIN   = 'h18;
    localparam int SLOT_SRC_W = 7;
    localparam int WIN_SRC_LSB = 16;

    function automatic int bank_base(input int b);
        case (b)
            0:       return 'h000;
            1:       return 'h09C;
            2:       return 'h130;
            default: return 'h244;
        endcase
    endfunction

    function automatic int slot_addr(input int i);
        if (i < 32)      return 'h01C + 4 * i;
        else if (i < 64) return 'h0B0 + 4 * (i - 32);
        else             return 'h144 + 4 * (i - 64);
    endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int ADDR_W = 10,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [31:0]       src,
    output logic              rd_hit,
    output logic [31:0]       rd_data,
    output logic [31:0]       norm_view,
    output logic [31:0]       fast_view,
    output logic [31:0]       en_view
);
    localparam logic [ADDR_W-1:0] A_NORM  = ADDR_W'(BASE + irqc_pkg::OFF_NORM);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(BASE + irqc_pkg::OFF_EN);
    localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(BASE + irqc_pkg::OFF_ROUTE);
    localparam logic [ADDR_W-1:0] A_FAST  = ADDR_W'(BASE + irqc_pkg::OFF_FAST);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(BASE + irqc_pkg::OFF_RAW);

    logic [31:0] en_q;
    logic [31:0] route_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
        end else if (wr_en) begin
            if (addr == A_EN)    en_q    <= wdata;
            if (addr == A_ROUTE) route_q <= wdata;
        end
    end

    assign en_view   = src & en_q;
    assign norm_view = en_view & ~route_q;
    assign fast_view = en_view & route_q;

    always_comb begin
        rd_hit  = 1'b1;
        rd_data = '0;
        if (addr == A_NORM)       rd_data = norm_view;
        else if (addr == A_EN)    rd_data = en_q;
        else if (addr == A_ROUTE) rd_data = route_q;
        else if (addr == A_FAST)  rd_data = fast_view;
        else if (addr == A_RAW)   rd_data = src;
        else                      rd_hit  = 1'b0;
    end

    // R4: a write to the enable word lands there on the next cycle
    assert_en_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_EN) |=> (en_q == $past(wdata)));

    // R10: a write to a view leaves the stored words unchanged
    assert_view_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_NORM || addr == A_FAST || addr == A_RAW))
        |=> ($stable(en_q) && $stable(route_q)));
endmodule

// File: rtl/irqc_slots.sv
module irqc_slots #(
    parameter int ADDR_W    = 10,
    parameter int NUM_SLOTS = 64,
    parameter int NUM_SRC   = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [31:0]                       wdata,
    input  logic [NUM_SRC-1:0]                eligible,
    output logic                              rd_hit,
    output logic [31:0]                       rd_data,
    output logic                              win_valid,
    output logic [irqc_pkg::SLOT_SRC_W-1:0]   win_src
);
    localparam int SW    = irqc_pkg::SLOT_SRC_W;
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [SW-1:0]        slot_src_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_vld_q;
    logic [NUM_SLOTS-1:0] slot_sel;
    logic [NUM_SLOTS-1:0] slot_cand;
    logic [IDX_W-1:0]     win_idx;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign slot_sel[i] = (addr == ADDR_W'(irqc_pkg::slot_addr(i)));
        assign slot_cand[i] = slot_vld_q[i]
                           && (int'(slot_src_q[i]) < NUM_SRC)
                           && eligible[slot_src_q[i][SRC_W-1:0]];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_src_q[i] <= '0;
                slot_vld_q[i] <= 1'b0;
            end else if (wr_en && slot_sel[i]) begin
                slot_src_q[i] <= wdata[SW-1:0];
                slot_vld_q[i] <= wdata[31];
            end
        end
    end

    always_comb begin
        rd_hit  = |slot_sel;
        rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_sel[i]) rd_data = {slot_vld_q[i], {(31-SW){1'b0}}, slot_src_q[i]};
        end
    end

    // Lowest slot index wins: scan downward so the last match kept is the lowest.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_src   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slot_cand[i]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_src   = slot_src_q[i];
            end
        end
    end

    // R7: a reported winner is enabled, pending and routed to the normal output
    assert_win_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((int'(win_src) < NUM_SRC) && eligible[win_src[SRC_W-1:0]]));

    // R8: the winning slot carries its valid flag
    assert_win_slot_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> slot_vld_q[win_idx]);
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 10,
    localparam int NUM_SRC  = 32 * NUM_BANKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               wake_o
);
    localparam int SW = irqc_pkg::SLOT_SRC_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(irqc_pkg::OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(irqc_pkg::OFF_WIN);

    logic [NUM_SRC-1:0] norm_all, fast_all, en_all;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [31:0] bank_rdata [NUM_BANKS];
    logic        slot_hit;
    logic [31:0] slot_rdata;
    logic        win_valid;
    logic [SW-1:0] win_src;
    logic        ctrl_q;
    logic        past_ok;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqc_bank #(.ADDR_W(ADDR_W), .BASE(irqc_pkg::bank_base(b))) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_wr),
            .addr      (bus_addr),
            .wdata     (bus_wdata),
            .src       (src_i[32*b +: 32]),
            .rd_hit    (bank_hit[b]),
            .rd_data   (bank_rdata[b]),
            .norm_view (norm_all[32*b +: 32]),
            .fast_view (fast_all[32*b +: 32]),
            .en_view   (en_all[32*b +: 32])
        );
    end

    irqc_slots #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SRC), .NUM_SRC(NUM_SRC)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .eligible  (norm_all),
        .rd_hit    (slot_hit),
        .rd_data   (slot_rdata),
        .win_valid (win_valid),
        .win_src   (win_src)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= 1'b0;
            irq_o   <= 1'b0;
            fiq_o   <= 1'b0;
            wake_o  <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[0];
            irq_o   <= |norm_all;
            fiq_o   <= |fast_all;
            wake_o  <= ctrl_q ? |en_all : |src_i;
            past_ok <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)
            bus_rdata = {31'b0, ctrl_q};
        else if (bus_addr == A_WIN)
            bus_rdata = win_valid ? {1'b1, {(15-SW){1'b0}}, win_src, 16'b0} : 32'b0;
        else if (slot_hit)
            bus_rdata = slot_rdata;
        else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_hit[b]) bus_rdata = bank_rdata[b];
            end
        end
    end

    // R5: normal and fast outputs follow the bank views one clock later
    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_o == $past(|norm_all)));
    assert_fiq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (fiq_o == $past(|fast_all)));

    // R9: with the control bit clear, wake tracks the raw inputs
    assert_wake_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(ctrl_q)) |-> (wake_o == $past(|src_i)));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    localparam int NB = 2;
    localparam int NS = 32 * NB;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o, fiq_o, wake_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irqc_top #(.NUM_BANKS(NB), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // outputs registered: apply at negedge, sampled one full cycle later
    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 en0", 'h004, 0);
        rd_chk("R1 route0", 'h008, 0);
        rd_chk("R1 en1", 'h0A0, 0);
        rd_chk("R1 ctrl", 'h014, 0);
        rd_chk("R1 win", 'h018, 0);
        rd_chk("R1 slot0", 'h01C, 0);
        chk("R1 outputs", {29'b0, irq_o, fiq_o, wake_o}, 0);
    endtask

    task automatic t_views();
        @(negedge clk);
        src_i = {32'h1234_5678, 32'hA5A5_0F0F};
        wr('h004, 32'hFFFF_0000);
        wr('h008, 32'h0F00_0000);
        rd_chk("R2 raw bank0", 'h010, 32'hA5A5_0F0F);
        rd_chk("R2 raw bank1", 'h0AC, 32'h1234_5678);
        rd_chk("R3 normal view", 'h000, 32'hA0A5_0000);
        rd_chk("R3 fast view", 'h00C, 32'h0500_0000);
        rd_chk("R3 bank1 view masked", 'h09C, 0);
        rd_chk("R4 enable readback", 'h004, 32'hFFFF_0000);
        rd_chk("R4 route readback", 'h008, 32'h0F00_0000);
        wr('h0A0, 32'h8000_0001);
        rd_chk("R4 bank1 enable", 'h0A0, 32'h8000_0001);
        rd_chk("R3 bank1 normal view", 'h09C, 32'h0000_0000);
        @(negedge clk);
        src_i[63] = 1'b1;
        #1;
        rd_chk("R2 live bank1", 'h0AC, 32'h9234_5678);
        rd_chk("R3 bank1 bit31 view", 'h09C, 32'h8000_0000);
    endtask

    task automatic t_outputs();
        settle();
        chk("R5 irq high", {31'b0, irq_o}, 1);
        chk("R5 fiq high", {31'b0, fiq_o}, 1);
        wr('h004, 0);
        wr('h0A0, 0);
        rd_chk("R3 cleared view", 'h000, 0);
        settle();
        chk("R5 irq low after disable", {31'b0, irq_o}, 0);
        chk("R5 fiq low after disable", {31'b0, fiq_o}, 0);
        wr('h008, 32'h0000_0008);
        wr('h004, 32'h0000_0008);
        settle();
        chk("R5 fast only irq", {31'b0, irq_o}, 0);
        chk("R5 fast only fiq", {31'b0, fiq_o}, 1);
        wr('h004, 0);
        wr('h008, 0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        src_i = '0;
        src_i[5] = 1'b1;
        src_i[40] = 1'b1;
        wr('h004, 32'h0000_0020);
        wr('h0A0, 32'h0000_0100);
        wr('h01C, 32'h0000_0005);
        wr('h020, 32'h8000_0028);
        wr('h024, 32'h8000_0005);
        rd_chk("R7 lowest valid slot wins", 'h018, 32'h8028_0000);
        wr('h020, 32'h0000_0028);
        rd_chk("R8 invalid slot skipped", 'h018, 32'h8005_0000);
        wr('h01C, 32'h8000_0064);
        rd_chk("R8 out of range source skipped", 'h018, 32'h8005_0000);
        wr('h020, 32'h8000_0028);
        wr('h0A4, 32'h0000_0100);
        rd_chk("R8 fast routed source skipped", 'h018, 32'h8005_0000);
        wr('h004, 0);
        rd_chk("R7 none pending reads zero", 'h018, 0);
        wr('h028, 32'hFFFF_FFFF);
        rd_chk("R6 slot field layout", 'h028, 32'h8000_007F);
        wr('h0D0, 32'h8000_0021);
        rd_chk("R6 slot 40 address", 'h0D0, 32'h8000_0021);
        wr('h0A4, 0);
        wr('h0A0, 0);
    endtask

    task automatic t_wake();
        @(negedge clk);
        src_i = '0;
        src_i[7] = 1'b1;
        settle();
        chk("R9 raw wake", {31'b0, wake_o}, 1);
        wr('h014, 32'hFFFF_FFFF);
        rd_chk("R9 ctrl readback", 'h014, 1);
        settle();
        chk("R9 enabled-only wake blocked", {31'b0, wake_o}, 0);
        wr('h004, 32'h0000_0080);
        settle();
        chk("R9 enabled-only wake", {31'b0, wake_o}, 1);
        wr('h004, 0);
        wr('h014, 0);
        @(negedge clk);
        src_i = '0;
    endtask

    task automatic t_readonly();
        @(negedge clk);
        src_i = '0;
        src_i[2] = 1'b1;
        wr('h004, 32'h0000_0004);
        wr('h01C, 32'h8000_0002);
        wr('h000, 32'hFFFF_FFFF);
        wr('h00C, 32'hFFFF_FFFF);
        wr('h010, 32'hFFFF_FFFF);
        wr('h018, 32'h0000_0000);
        rd_chk("R10 enable kept", 'h004, 32'h0000_0004);
        rd_chk("R10 route kept", 'h008, 0);
        rd_chk("R10 raw unchanged", 'h010, 32'h0000_0004);
        rd_chk("R10 win unchanged", 'h018, 32'h8002_0000);
        wr('h130, 32'hFFFF_FFFF);
        wr('h144, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped bank2", 'h130, 0);
        rd_chk("R10 unmapped slot64", 'h144, 0);
        rd_chk("R10 misaligned", 'h005, 0);
        rd_chk("R10 bank1 enable kept", 'h0A0, 0);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_views();
        t_outputs();
        t_priority();
        t_wake();
        t_readonly();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule